// File: doc/BRIEF.md
# Edge Boundary Mask Generator

This unit turns the two byte addresses that bound a span (the current address and the last address) into a partial-store mask for one aligned 8-byte block. Software-style loops that copy or fill unaligned spans use it at both ends of the span. The first block gets a mask that starts at the current address. The last block gets a mask that is also cut off at the end address. Elements can be 8, 16 or 32 bits wide, and the mask can be oriented big-endian or little-endian. In big-endian orientation the lowest address maps to the most significant mask bit.

A request is presented with `reqValid` and its result appears on the registered outputs one clock later. A set-flags request also records the condition codes of the subtraction current minus end, for both a 32-bit and a 64-bit result width. A request without that bit leaves the recorded flags untouched. A narrow-address mode restricts the same-block comparison to the low 32 address bits.

Top module: `edge_mask_unit`

## Requirements
- R1: After reset `respValid`, `flagsValid`, `maskOut`, `ccWide` and `ccNarrow` are all zero.
- R2: `respValid` is high exactly in the cycle after a cycle with `reqValid` high, and low otherwise.
- R3: With `elemSize` 0 (8-bit) and `littleEnd` 0, let i = `addrA[2:0]` and j = `addrB[2:0]`. The left mask is 0xFF shifted right by i. The right mask has its top j+1 bits set.
- R4: With `elemSize` 0 and `littleEnd` 1, the left mask is 0xFF shifted left by i, truncated to 8 bits. The right mask has its low j+1 bits set.
- R5: With `elemSize` 1 (16-bit) the indices are address bits 2..1 and the masks are 4 bits wide. With `elemSize` 2 (32-bit) the index is address bit 2 and the masks are 2 bits wide. The same orientation rules as R3/R4 apply. `elemSize` 3 behaves as 8-bit.
- R6: If the two addresses are equal in every bit from bit 3 upward, `maskOut` is left AND right. Otherwise `maskOut` is the left mask alone.
- R7: With `narrowMode` 1 the same-block test of R6 uses only address bits 31..3, and higher bits are ignored.
- R8: On a set-flags request `ccWide` and `ccNarrow` take {N,Z,V,C} (bit 3 down to bit 0) of `addrA - addrB`. The wide flags use the 64-bit difference and the narrow flags use the low-32-bit difference. C means an unsigned borrow. The full addresses are used in both modes.
- R9: `flagsValid` is high with `respValid` only for set-flags requests. A request without set-flags leaves `ccWide` and `ccNarrow` unchanged.
- R10: `maskOut` is the mask zero-extended to 64 bits, so bits 63..8 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| addrA | input | 64 | Current (first) address |
| addrB | input | 64 | End (second) address |
| elemSize | input | 2 | 0: 8-bit, 1: 16-bit, 2: 32-bit, 3: 8-bit |
| littleEnd | input | 1 | Little-endian mask orientation |
| setFlags | input | 1 | Record condition codes for this request |
| narrowMode | input | 1 | 32-bit address mode for block comparison |
| respValid | output | 1 | Result valid, one cycle after request |
| maskOut | output | 64 | Zero-extended partial-store mask |
| ccWide | output | 4 | {N,Z,V,C} of the 64-bit subtraction |
| ccNarrow | output | 4 | {N,Z,V,C} of the 32-bit subtraction |
| flagsValid | output | 1 | Flags were updated by this response |

## Verification
A wrong size select or a wrong orientation shows as a misplaced mask bit in the very response to the request that triggered it. A broken block comparison shows only on spans that end in the same block, or only when the high address halves differ in narrow mode, so those cases are driven directly. A flag register that loads when it should hold does not show in that response. It shows as changed flag values in the response of the next request that does not set flags, and the bench tracks the held values across requests to catch this.

// File: rtl/edge_pkg.sv
package edge_pkg;

  typedef enum logic [1:0] {
    SIZE_BYTE = 2'd0,
    SIZE_HALF = 2'd1,
    SIZE_WORD = 2'd2,
    SIZE_ALT  = 2'd3
  } elemSize_e;

  localparam int NUM_SIZES = 3;

  typedef struct packed {
    logic                 loadMask;
    logic                 loadFlags;
    logic                 littleEnd;
    logic                 narrow;
    logic [NUM_SIZES-1:0] sizeOneHot;
  } ctrlStrobes_t;

endpackage

// File: rtl/edge_ctrl.sv
module edge_ctrl
  import edge_pkg::*;
(
  input  logic         reqValid,
  input  logic [1:0]   elemSize,
  input  logic         littleEnd,
  input  logic         setFlags,
  input  logic         narrowMode,
  output ctrlStrobes_t strobes
);

  elemSize_e sizeCode;

  always_comb begin
    sizeCode = elemSize_e'(elemSize);
    strobes.loadMask  = reqValid;
    strobes.loadFlags = reqValid & setFlags;
    strobes.littleEnd = littleEnd;
    strobes.narrow    = narrowMode;
    unique case (sizeCode)
      SIZE_HALF: strobes.sizeOneHot = 3'b010;
      SIZE_WORD: strobes.sizeOneHot = 3'b100;
      default:   strobes.sizeOneHot = 3'b001;
    endcase
  end

endmodule

// File: rtl/edge_datapath.sv
module edge_datapath
  import edge_pkg::*;
#(
  parameter int ADDR_W      = 64,
  parameter int BLOCK_BYTES = 8,
  parameter int NARROW_W    = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] addrA,
  input  logic [ADDR_W-1:0] addrB,
  output logic [ADDR_W-1:0] maskOut,
  output logic [3:0]        ccWide,
  output logic [3:0]        ccNarrow,
  output logic              respValid,
  output logic              flagsValid
);

  localparam int IDX_W = $clog2(BLOCK_BYTES);

  logic [BLOCK_BYTES-1:0] leftBy  [NUM_SIZES];
  logic [BLOCK_BYTES-1:0] rightBy [NUM_SIZES];
  logic [BLOCK_BYTES-1:0] leftSel, rightSel, maskNext, maskReg;
  logic                   sameBlock;

  // One mask generator per element size; lane count halves per step.
  for (genvar g = 0; g < NUM_SIZES; g++) begin : gSize
    localparam int LANES = BLOCK_BYTES >> g;
    logic [IDX_W-1-g:0] idxL, idxR;
    assign idxL = addrA[IDX_W-1:g];
    assign idxR = addrB[IDX_W-1:g];
    always_comb begin
      leftBy[g]  = '0;
      rightBy[g] = '0;
      for (int j = 0; j < LANES; j++) begin
        int pos;
        pos = strobes.littleEnd ? j : (LANES - 1 - j);
        leftBy[g][j]  = (pos >= int'(idxL));
        rightBy[g][j] = (pos <= int'(idxR));
      end
    end
  end

  always_comb begin
    leftSel  = '0;
    rightSel = '0;
    for (int g = 0; g < NUM_SIZES; g++) begin
      if (strobes.sizeOneHot[g]) begin
        leftSel  = leftSel  | leftBy[g];
        rightSel = rightSel | rightBy[g];
      end
    end
  end

  always_comb begin
    if (strobes.narrow)
      sameBlock = (addrA[NARROW_W-1:IDX_W] == addrB[NARROW_W-1:IDX_W]);
    else
      sameBlock = (addrA[ADDR_W-1:IDX_W] == addrB[ADDR_W-1:IDX_W]);
    maskNext = sameBlock ? (leftSel & rightSel) : leftSel;
  end

  // Condition codes of addrA - addrB at both widths (full values).
  logic [ADDR_W-1:0]   diffWide;
  logic                borrowWide;
  logic [NARROW_W-1:0] diffNarrow;
  logic                borrowNarrow;
  logic [3:0]          ccWideNext, ccNarrowNext;

  always_comb begin
    {borrowWide, diffWide}     = {1'b0, addrA} - {1'b0, addrB};
    {borrowNarrow, diffNarrow} = {1'b0, addrA[NARROW_W-1:0]} - {1'b0, addrB[NARROW_W-1:0]};
    ccWideNext = {diffWide[ADDR_W-1], (diffWide == '0),
                  (addrA[ADDR_W-1] ^ addrB[ADDR_W-1]) & (addrA[ADDR_W-1] ^ diffWide[ADDR_W-1]),
                  borrowWide};
    ccNarrowNext = {diffNarrow[NARROW_W-1], (diffNarrow == '0),
                    (addrA[NARROW_W-1] ^ addrB[NARROW_W-1]) & (addrA[NARROW_W-1] ^ diffNarrow[NARROW_W-1]),
                    borrowNarrow};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg    <= '0;
      ccWide     <= '0;
      ccNarrow   <= '0;
      respValid  <= 1'b0;
      flagsValid <= 1'b0;
    end else begin
      respValid  <= strobes.loadMask;
      flagsValid <= strobes.loadFlags;
      if (strobes.loadMask) maskReg <= maskNext;
      if (strobes.loadFlags) begin
        ccWide   <= ccWideNext;
        ccNarrow <= ccNarrowNext;
      end
    end
  end

  assign maskOut = {{(ADDR_W-BLOCK_BYTES){1'b0}}, maskReg};

  // R2: response follows the request by one cycle
  a_r2_latency: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadMask |=> respValid);

  // R6: final mask never exceeds the left mask
  a_r6_within_left: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadMask |=> ((maskReg & ~$past(leftSel)) == '0));

  // R8: equal addresses give the zero flag at both widths
  a_r8_zero_flag: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadFlags && addrA == addrB) |=> (ccWide[2] && ccNarrow[2] && !ccWide[0]));

  // R9: flags hold when not loaded
  a_r9_flags_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadFlags |=> ($stable(ccWide) && $stable(ccNarrow)));

  // R9: flagsValid only together with a response
  a_r9_flags_with_resp: assert property (@(posedge clk) disable iff (!rstN)
    flagsValid |-> respValid);

endmodule

// File: rtl/edge_mask_unit.sv
module edge_mask_unit
  import edge_pkg::*;
#(
  parameter int ADDR_W      = 64,
  parameter int BLOCK_BYTES = 8,
  parameter int NARROW_W    = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] addrA,
  input  logic [ADDR_W-1:0] addrB,
  input  logic [1:0]        elemSize,
  input  logic              littleEnd,
  input  logic              setFlags,
  input  logic              narrowMode,
  output logic              respValid,
  output logic [ADDR_W-1:0] maskOut,
  output logic [3:0]        ccWide,
  output logic [3:0]        ccNarrow,
  output logic              flagsValid
);

  ctrlStrobes_t strobes;

  edge_ctrl i_ctrl (
    .reqValid  (reqValid),
    .elemSize  (elemSize),
    .littleEnd (littleEnd),
    .setFlags  (setFlags),
    .narrowMode(narrowMode),
    .strobes   (strobes)
  );

  edge_datapath #(
    .ADDR_W     (ADDR_W),
    .BLOCK_BYTES(BLOCK_BYTES),
    .NARROW_W   (NARROW_W)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .addrA     (addrA),
    .addrB     (addrB),
    .maskOut   (maskOut),
    .ccWide    (ccWide),
    .ccNarrow  (ccNarrow),
    .respValid (respValid),
    .flagsValid(flagsValid)
  );

endmodule

// File: tb/test_edge_mask_unit.sv
module test_edge_mask_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [63:0] addrA = '0, addrB = '0;
  logic [1:0]  elemSize = '0;
  logic        littleEnd = 1'b0, setFlags = 1'b0, narrowMode = 1'b0;
  logic        respValid, flagsValid;
  logic [63:0] maskOut;
  logic [3:0]  ccWide, ccNarrow;

  int checks = 0;
  int fails = 0;
  logic [3:0] heldWide = '0, heldNarrow = '0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  edge_mask_unit i_edge_mask_unit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .addrA(addrA), .addrB(addrB),
    .elemSize(elemSize), .littleEnd(littleEnd), .setFlags(setFlags),
    .narrowMode(narrowMode), .respValid(respValid), .maskOut(maskOut),
    .ccWide(ccWide), .ccNarrow(ccNarrow), .flagsValid(flagsValid)
  );

  function automatic logic [7:0] expMask(input logic [63:0] a, input logic [63:0] b,
                                         input logic [1:0] sz, input logic le, input logic nar);
    int i, j;
    logic [7:0] l, r;
    logic same;
    case (sz)
      2'd1: begin
        i = int'(a[2:1]); j = int'(b[2:1]);
        l = le ? 8'((15 << i) & 15) : 8'(15 >> i);
        r = le ? 8'(15 >> (3 - j)) : 8'((15 << (3 - j)) & 15);
      end
      2'd2: begin
        i = int'(a[2]); j = int'(b[2]);
        l = le ? 8'((3 << i) & 3) : 8'(3 >> i);
        r = le ? 8'(3 >> (1 - j)) : 8'((3 << (1 - j)) & 3);
      end
      default: begin
        i = int'(a[2:0]); j = int'(b[2:0]);
        l = le ? 8'((255 << i) & 255) : 8'(255 >> i);
        r = le ? 8'(255 >> (7 - j)) : 8'((255 << (7 - j)) & 255);
      end
    endcase
    same = nar ? (a[31:3] == b[31:3]) : (a[63:3] == b[63:3]);
    return same ? (l & r) : l;
  endfunction

  function automatic logic [3:0] expFlags64(input logic [63:0] a, input logic [63:0] b);
    logic [64:0] d;
    d = {1'b0, a} - {1'b0, b};
    return {d[63], d[63:0] == 64'd0, (a[63] != b[63]) && (d[63] != a[63]), d[64]};
  endfunction

  function automatic logic [3:0] expFlags32(input logic [31:0] a, input logic [31:0] b);
    logic [32:0] d;
    d = {1'b0, a} - {1'b0, b};
    return {d[31], d[31:0] == 32'd0, (a[31] != b[31]) && (d[31] != a[31]), d[32]};
  endfunction

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doOp(input logic [63:0] a, input logic [63:0] b, input logic [1:0] sz,
                      input logic le, input logic sf, input logic nar);
    string mTag;
    logic [7:0] em;
    @(negedge clk);
    addrA = a; addrB = b; elemSize = sz; littleEnd = le; setFlags = sf;
    narrowMode = nar; reqValid = 1'b1;
    em = expMask(a, b, sz, le, nar);
    if (sf) begin
      heldWide = expFlags64(a, b);
      heldNarrow = expFlags32(a[31:0], b[31:0]);
    end
    if (sz == 2'd1 || sz == 2'd2) mTag = "R5 mask";
    else if (le) mTag = "R4 mask";
    else mTag = "R3 mask";
    @(negedge clk);
    reqValid = 1'b0;
    check(64'(respValid), 64'd1, "R2 respValid");
    check(maskOut, {56'd0, em}, mTag);
    check(64'(maskOut[63:8]), 64'd0, "R10 upper bits");
    check(64'(flagsValid), 64'(sf), "R9 flagsValid");
    check(64'(ccWide), 64'(heldWide), sf ? "R8 ccWide" : "R9 ccWide held");
    check(64'(ccNarrow), 64'(heldNarrow), sf ? "R8 ccNarrow" : "R9 ccNarrow held");
  endtask

  initial begin
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(64'(respValid), 64'd0, "R1 respValid");
    check(64'(flagsValid), 64'd0, "R1 flagsValid");
    check(maskOut, 64'd0, "R1 maskOut");
    check(64'({ccWide, ccNarrow}), 64'd0, "R1 flags");

    // R3/R6 directed: same block, big-endian bytes
    doOp(64'h1000_0002, 64'h1000_0005, 2'd0, 1'b0, 1'b0, 1'b0);
    check(maskOut, 64'h3C, "R6 same block AND");
    // R6: different block -> left only
    doOp(64'h1000_0002, 64'h1000_0015, 2'd0, 1'b0, 1'b0, 1'b0);
    check(maskOut, 64'h3F, "R6 other block left only");
    // R4 little-endian
    doOp(64'h20_0003, 64'h20_0006, 2'd0, 1'b1, 1'b0, 1'b0);
    check(maskOut, 64'h78, "R4 LE same block");
    // R5 16-bit and 32-bit, and size code 3
    doOp(64'h2, 64'h4, 2'd1, 1'b0, 1'b0, 1'b0);
    check(maskOut, 64'h6, "R5 half BE");
    doOp(64'h4, 64'h4, 2'd2, 1'b1, 1'b0, 1'b0);
    check(maskOut, 64'h2, "R5 word LE");
    doOp(64'h7, 64'h7, 2'd3, 1'b0, 1'b0, 1'b0);
    check(maskOut, 64'h01, "R5 size code 3 as byte");
    // R7 narrow mode ignores upper half
    doOp(64'h0000_0100_0000_0010, 64'h0000_0000_0000_0013, 2'd0, 1'b0, 1'b0, 1'b1);
    check(maskOut, 64'hF0, "R7 narrow same block");
    doOp(64'h0000_0100_0000_0010, 64'h0000_0000_0000_0013, 2'd0, 1'b0, 1'b0, 1'b0);
    check(maskOut, 64'hFF, "R7 wide different block");
    // R8 flags corners
    doOp(64'h5, 64'h5, 2'd0, 1'b0, 1'b1, 1'b0);
    check(64'(ccWide), 64'h4, "R8 equal wide Z");
    doOp(64'h0, 64'h1, 2'd0, 1'b0, 1'b1, 1'b0);
    check(64'(ccWide), 64'h9, "R8 borrow wide N,C");
    doOp(64'h8000_0000_0000_0000, 64'h1, 2'd0, 1'b0, 1'b1, 1'b0);
    check(64'(ccWide), 64'h2, "R8 wide overflow");
    check(64'(ccNarrow), 64'h9, "R8 narrow borrow");
    // R9 flags hold
    doOp(64'h9, 64'h3, 2'd1, 1'b1, 1'b0, 1'b1);
    // R2 idle cycle
    @(negedge clk);
    check(64'(respValid), 64'd0, "R2 idle");

    for (int n = 0; n < 400; n++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      if ($urandom_range(0, 2) == 0) b = {$urandom, $urandom};
      else if ($urandom_range(0, 1) == 0) b = {a[63:32] ^ 32'($urandom_range(0, 1) << 5), a[31:3], 3'($urandom)};
      else b = {a[63:3], 3'($urandom)};
      doOp(a, b, 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule